// File: doc/BRIEF.md
# Timed Parallel Sample Streamer

The block moves wide parallel words between a host-side stream and a set of pins at a fixed, programmable rate. An internal divider produces one update pulse every `rate_div` clock cycles. On each update the block drives the oldest queued host word onto `pin_out` and, on the same edge, stores the current `pin_in` word in a receive queue that the host drains. Input capture and output update therefore share one pacing source. Host traffic on either queue never moves an update.

When the transmit queue is empty at an update, the pins keep their previous word and an underflow counter records the gap. When the receive queue is full, the new sample is discarded and an overflow counter records it. Software can watch these counters and lower the rate until neither of them moves. Both queue fill levels are visible. While the streamer is stopped, a flush empties both queues and clears both counters.

Top module: `sio_streamer`

## Requirements
- R1: After reset `pin_out` is all zeros, both fill levels and both counters are zero, `in_rd_valid` is 0 and `out_wr_ready` is 1.
- R2: With `enable` held high, updates occur every `rate_div` cycles, and a value of 0 acts as 1. The first update takes effect at the rising edge numbered `rate_div`+1, counting the first edge that samples `enable` high as edge 1.
- R3: `pin_out` changes only at an update, and it shows the transmit-queue words in the order the host wrote them.
- R4: At each update, the `pin_in` value sampled on that edge is appended to the receive queue. The host reads those values back in capture order through `in_rd_valid`/`in_rd_ready`/`in_rd_data`.
- R5: An update that finds the transmit queue empty leaves `pin_out` unchanged and adds one to `underflow_cnt`, which saturates at its maximum.
- R6: An update that finds the receive queue holding DEPTH (256) words drops the sample and adds one to `overflow_cnt`, which saturates. Words already stored are kept unchanged.
- R7: A host word is taken on a clock edge where both `out_wr_valid` and `out_wr_ready` are high. `out_wr_ready` is low while the transmit queue holds 256 words, and a write offered then is not stored.
- R8: `out_level` and `in_level` give the number of words held in each queue.
- R9: A `flush` high while `enable` is low empties both queues and clears both counters on the next edge. A `flush` while `enable` is high has no effect.
- R10: With `enable` low no update occurs. Each time `enable` goes high again, a full period passes before the first update, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the rate divider and allow updates |
| flush | input | 1 | Clear queues and counters while stopped |
| rate_div | input | 32 | Update period in clock cycles |
| out_wr_valid | input | 1 | Host offers a transmit word |
| out_wr_data | input | 64 | Transmit word |
| out_wr_ready | output | 1 | Transmit queue has room |
| in_rd_valid | output | 1 | Receive queue holds a word |
| in_rd_data | output | 64 | Oldest received word |
| in_rd_ready | input | 1 | Host takes the oldest received word |
| pin_in | input | 64 | Parallel input pins |
| pin_out | output | 64 | Parallel output pins |
| out_level | output | 9 | Transmit queue fill level |
| in_level | output | 9 | Receive queue fill level |
| underflow_cnt | output | 16 | Saturating count of empty-queue updates |
| overflow_cnt | output | 16 | Saturating count of dropped samples |

## Verification
The divider registers its pulse, so an update falls one edge after the divider wraps, and `pin_out` settles at edge `rate_div`+1 after enable. From there it changes every `rate_div` edges. The bench counts falling edges from the one where it raised `enable`. It checks `pin_out` one edge before the update is due and again right after, and it changes `pin_in` only just after an update, so each captured word is known. Levels, counters and the queue heads respond one edge after a write, read or flush, and the bench samples them on the next falling edge. A scoreboard monitor matches every change of `pin_out` against the queue of words written by the host.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Increment with saturation at the all-ones value.
    function automatic logic [15:0] sat_inc16(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

endpackage

// File: rtl/sio_rate_timer.sv
module sio_rate_timer #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [DIV_W-1:0] period_eff;

    always_comb begin
        period_eff = (period == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : period;
        st_d       = st_q;
        st_d.tick  = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= period_eff - 1'b1) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick) else $error("tick while stopped"); // R10

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && period > 1) |=> !tick) else $error("ticks too close"); // R2

endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  logic [W-1:0]           push_data,
    input  logic                   pop,
    output logic                   full,
    output logic                   empty,
    output logic [W-1:0]           head,
    output logic [$clog2(DEPTH):0] level
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   count;
    } ptr_t;

    ptr_t         st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         push_ok, pop_ok;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.count == (AW+1)'(DEPTH));
    assign empty   = (st_q.count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wptr = wrap_inc(st_q.wptr);
            if (pop_ok)  st_d.rptr = wrap_inc(st_q.rptr);
            case ({push_ok, pop_ok})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wptr] <= push_data;
    end

    assign head  = mem[st_q.rptr];
    assign level = st_q.count;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH)) else $error("level above depth"); // R8

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> level == $past(level)) else $error("write into full queue"); // R7

endmodule

// File: rtl/sio_streamer.sv
module sio_streamer #(
    parameter int W     = 64,
    parameter int DEPTH = 256,
    parameter int DIV_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   flush,
    input  logic [DIV_W-1:0]       rate_div,
    input  logic                   out_wr_valid,
    input  logic [W-1:0]           out_wr_data,
    output logic                   out_wr_ready,
    output logic                   in_rd_valid,
    output logic [W-1:0]           in_rd_data,
    input  logic                   in_rd_ready,
    input  logic [W-1:0]           pin_in,
    output logic [W-1:0]           pin_out,
    output logic [$clog2(DEPTH):0] out_level,
    output logic [$clog2(DEPTH):0] in_level,
    output logic [15:0]            underflow_cnt,
    output logic [15:0]            overflow_cnt
);
    import sio_pkg::*;

    typedef struct packed {
        logic [W-1:0] pins;
        logic [15:0]  udf;
        logic [15:0]  ovf;
    } io_t;

    io_t          st_d, st_q;
    logic         tick, upd, clr;
    logic         tx_full, tx_empty, rx_full, rx_empty;
    logic [W-1:0] tx_head;

    sio_rate_timer #(.DIV_W(DIV_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .run(enable), .period(rate_div), .tick(tick)
    );

    assign upd = tick && enable;
    assign clr = flush && !enable;

    sio_fifo #(.W(W), .DEPTH(DEPTH)) i_tx_q (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(out_wr_valid), .push_data(out_wr_data),
        .pop(upd), .full(tx_full), .empty(tx_empty),
        .head(tx_head), .level(out_level)
    );

    sio_fifo #(.W(W), .DEPTH(DEPTH)) i_rx_q (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(upd), .push_data(pin_in),
        .pop(in_rd_ready), .full(rx_full), .empty(rx_empty),
        .head(in_rd_data), .level(in_level)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.udf = '0;
            st_d.ovf = '0;
        end else if (upd) begin
            if (tx_empty) st_d.udf  = sat_inc16(st_q.udf);
            else          st_d.pins = tx_head;
            if (rx_full)  st_d.ovf  = sat_inc16(st_q.ovf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out       = st_q.pins;
    assign underflow_cnt = st_q.udf;
    assign overflow_cnt  = st_q.ovf;
    assign out_wr_ready  = !tx_full;
    assign in_rd_valid   = !rx_empty;

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(pin_out)) else $error("pins moved off-update"); // R3

    AST_UNDERFLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && tx_empty && underflow_cnt != 16'hFFFF) |=> underflow_cnt == $past(underflow_cnt) + 16'd1)
        else $error("underflow not counted"); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && rx_full && !in_rd_ready) |=> in_level == $past(in_level)) else $error("sample stored into full queue"); // R6

    AST_FLUSH_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && enable && !upd && !out_wr_valid) |=> out_level == $past(out_level)) else $error("flush acted while running"); // R9

endmodule

// File: tb/test_sio_streamer.sv
module test_sio_streamer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, flush = 1'b0;
    logic [31:0] rate_div = 32'd5;
    logic        out_wr_valid = 1'b0;
    logic [63:0] out_wr_data = '0;
    logic        out_wr_ready, in_rd_valid, in_rd_ready = 1'b0;
    logic [63:0] in_rd_data, pin_out, pin_in = '0;
    logic [8:0]  out_level, in_level;
    logic [15:0] underflow_cnt, overflow_cnt;

    int checks = 0, fails = 0;
    logic [63:0] exp_q[$];
    logic [63:0] last_out = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sio_streamer i_sio_streamer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush), .rate_div(rate_div),
        .out_wr_valid(out_wr_valid), .out_wr_data(out_wr_data), .out_wr_ready(out_wr_ready),
        .in_rd_valid(in_rd_valid), .in_rd_data(in_rd_data), .in_rd_ready(in_rd_ready),
        .pin_in(pin_in), .pin_out(pin_out), .out_level(out_level), .in_level(in_level),
        .underflow_cnt(underflow_cnt), .overflow_cnt(overflow_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] tx_word(input int i);
        return 64'hA000_0000_0000_0000 | (64'(i) << 8) | 64'h5;
    endfunction

    function automatic logic [63:0] rx_word(input int i);
        return 64'h00C0_FFEE_0000_0000 | 64'(i * 3 + 1);
    endfunction

    // Driver: writes one host word, optionally recording it for the scoreboard.
    task automatic host_push(input logic [63:0] w, input bit track);
        out_wr_valid = 1'b1;
        out_wr_data  = w;
        @(negedge clk);
        out_wr_valid = 1'b0;
        if (track) exp_q.push_back(w);
    endtask

    task automatic host_pop(input logic [63:0] w, input string req);
        chk({req, " valid"}, 64'(in_rd_valid), 64'd1);
        chk({req, " data"}, in_rd_data, w);
        in_rd_ready = 1'b1;
        @(negedge clk);
        in_rd_ready = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Monitor: every change of pin_out must be the next expected word (R3).
    always @(negedge clk) begin
        if (rst_n && !done && pin_out !== last_out) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R3 unexpected pin_out actual=%h expected=%h", pin_out, last_out);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                if (pin_out !== e) begin
                    fails++;
                    $display("FAIL R3 order actual=%h expected=%h", pin_out, e);
                end
            end
            last_out = pin_out;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", pin_out, 64'd0);
        chk("R1 out_level", 64'(out_level), 64'd0);
        chk("R1 in_level", 64'(in_level), 64'd0);
        chk("R1 underflow", 64'(underflow_cnt), 64'd0);
        chk("R1 overflow", 64'(overflow_cnt), 64'd0);
        chk("R1 in_rd_valid", 64'(in_rd_valid), 64'd0);
        chk("R1 out_wr_ready", 64'(out_wr_ready), 64'd1);

        // R7 fill transmit queue while stopped
        for (int i = 0; i < 256; i++) host_push(64'(i), 1'b0);
        chk("R7 ready low when full", 64'(out_wr_ready), 64'd0);
        chk("R8 level full", 64'(out_level), 64'd256);
        host_push(64'hDEAD, 1'b0);
        chk("R7 write while full dropped", 64'(out_level), 64'd256);

        // R9 flush while running is ignored (period long, no update)
        rate_div = 32'd1000;
        enable = 1'b1;
        @(negedge clk);
        pulse_flush();
        chk("R9 flush ignored while enabled", 64'(out_level), 64'd256);
        enable = 1'b0;
        @(negedge clk);
        pulse_flush();
        chk("R9 flush empties tx", 64'(out_level), 64'd0);
        chk("R9 pin_out untouched", pin_out, 64'd0);

        // R2..R5 main streaming at period 5
        for (int i = 0; i < 4; i++) host_push(tx_word(i), 1'b1);
        chk("R8 level four", 64'(out_level), 64'd4);
        rate_div = 32'd5;
        pin_in = rx_word(0);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 no update before period", pin_out, 64'd0);
        @(negedge clk);
        chk("R2 first update at edge P+1", pin_out, tx_word(0));
        pin_in = rx_word(1);
        for (int u = 1; u < 6; u++) begin
            repeat (4) @(negedge clk);
            chk("R3 no change mid-period", pin_out, tx_word(u < 4 ? u - 1 : 3));
            @(negedge clk);
            pin_in = rx_word(u + 1);
        end
        chk("R5 pins hold last word", pin_out, tx_word(3));
        chk("R5 underflow count", 64'(underflow_cnt), 64'd2);
        chk("R4 in_level after six updates", 64'(in_level), 64'd6);
        enable = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 stopped no updates", 64'(underflow_cnt), 64'd2);
        for (int i = 0; i < 6; i++) host_pop(rx_word(i), "R4 capture order");
        chk("R8 in_level drained", 64'(in_level), 64'd0);

        // R10 re-enable waits a full period
        host_push(tx_word(9), 1'b1);
        enable = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 restart waits full period", pin_out, tx_word(3));
        @(negedge clk);
        chk("R10 restart update", pin_out, tx_word(9));
        enable = 1'b0;
        @(negedge clk);

        // R9 flush clears counters
        pulse_flush();
        chk("R9 counters cleared", 64'(underflow_cnt), 64'd0);

        // R6 overflow at period 0 (acts as 1)
        rate_div = 32'd0;
        pin_in = 64'd0;
        enable = 1'b1;
        for (int n = 1; n <= 262; n++) begin
            @(negedge clk);
            pin_in = 64'(n);
        end
        enable = 1'b0;
        @(negedge clk);
        chk("R6 in_level full", 64'(in_level), 64'd256);
        chk("R6 overflow count", 64'(overflow_cnt), 64'd5);
        chk("R2 period zero acts as one", 64'(underflow_cnt), 64'd261);
        host_pop(64'd1, "R6 first kept sample");
        host_pop(64'd2, "R6 second kept sample");

        done = 1'b1;
        chk("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule